// File: doc/BRIEF.md
# PCI Configuration Cycle Router

This block is the host end of the configuration access mechanism. The host reaches two 32-bit I/O registers. One is an address register that selects bus, device, function and register. The other is a data window. When the address register's enable bit is set, each window access is decoded and sent to one of four places:

- the bridge's own three functions on bus 0;
- a Type 0 cycle on the secondary bus, with a one-hot device select;
- a Type 1 cycle on the secondary bus for buses behind it;
- the downstream hub link.

Decodes that cannot reach a device end in a master abort. A master-abort read returns all ones. A master-abort write is dropped.

The generated cycle appears on registered outputs one clock after the host access. Read data returns one clock after that. For a routed read, the returned data is the value the target presents on `tgt_rdata` while `cyc_valid` is high. The secondary and subordinate bus numbers come from outside as plain inputs.

Top module: `cfg_router`

## Requirements
- R1: The address register sits at I/O address 0CF8h and resets to 0. Writes store bits 31:2. Bits 1:0 always read as 0.
- R2: The data window sits at I/O address 0CFCh and resets to 0. While address bit 31 is 0, the window behaves as a plain read/write register and no cycle or abort is produced.
- R3: With bit 31 set, the address fields are bus = bits 23:16, device = bits 15:11, function = bits 10:8 and register = bits 7:2. Bus 0 with device 0..2 and function 0 routes to the local functions (route code 0). The cycle address is bus·2^16 + dev·2^11 + fn·2^8 + reg·4.
- R4: Bus 0 with device 0..2 and a non-zero function gives a master abort (`cyc_abort` high, `cyc_valid` low).
- R5: When the bus is non-zero and equals `sec_bus`, the access is a Type 0 cycle (route code 1). Exactly one bit of address bits 31:16 is set, at bit 16+dev. Bits 15:11 are 0, the function is on bits 10:8, the register on bits 7:2, and bits 1:0 are 00.
- R6: A Type 0 decode with device above 15 sets no select bit and gives a master abort.
- R7: When `sec_bus` < bus <= `sub_bus`, the access is a Type 1 cycle (route code 2). The address is bus·2^16 + dev·2^11 + fn·2^8 + reg·4 + 1.
- R8: All other non-zero buses, and bus 0 devices 3..31, go to the hub link (route code 3). The address is the same as in R3.
- R9: An aborted read returns FFFFFFFFh. An aborted write issues no cycle and leaves the window register unchanged. A routed write carries its data on `cyc_wdata` and also updates the window register.
- R10: The `cyc_*` outputs are valid for one cycle, one clock after the window access. `io_rvalid` and `io_rdata` follow two clocks after any read of either port. Back-to-back accesses in consecutive cycles each see the address register as it stood after the previous access.
- R11: Accesses to other I/O addresses are ignored: no read response, no cycle, and no change of state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | Host I/O access strobe, one cycle per access |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 32 | Host write data |
| sec_bus | input | 8 | Secondary bus number |
| sub_bus | input | 8 | Subordinate bus number |
| tgt_rdata | input | 32 | Read data from the target while `cyc_valid` is high |
| io_rvalid | output | 1 | Host read data valid |
| io_rdata | output | 32 | Host read data |
| cyc_valid | output | 1 | Configuration cycle issued |
| cyc_write | output | 1 | Direction of the issued cycle |
| cyc_route | output | 2 | 0 local, 1 Type 0, 2 Type 1, 3 hub link |
| cyc_addr | output | 32 | Translated cycle address |
| cyc_wdata | output | 32 | Write data of the cycle |
| cyc_abort | output | 1 | Master abort on the decoded access |

## Verification
Two functions can land in the same cycle. One is the return of a window read's data in the second stage. The other is the decode of the next access in the first stage, which may be a write to the address register that changes the fields. The bench provokes this by issuing an address write, a window read, a second address write and a second window read on consecutive clocks. It then judges each cycle at the ports. Each decode must use the address written one clock earlier. Each returned word must match the target data computed from that read's own translated address, and must not be mixed with the neighbouring access. The sweep itself steps through every device number across buses 0, secondary, Type 1 range and hub-link, with function numbers 0 and non-zero.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;
  typedef enum logic [1:0] {
    RT_LOCAL = 2'd0,
    RT_TYPE0 = 2'd1,
    RT_TYPE1 = 2'd2,
    RT_HUB   = 2'd3
  } route_t;

  localparam int DEV_W = 5;
  localparam int FN_W  = 3;
  localparam int REG_W = 6;
  localparam int BUS_W = 8;
endpackage

// File: rtl/cfg_idsel_gen.sv
module cfg_idsel_gen #(
  parameter int DEV_W   = 5,
  parameter int IDSEL_N = 16
) (
  input  logic [DEV_W-1:0]   dev,
  output logic [IDSEL_N-1:0] idsel,
  output logic               in_range
);
  localparam logic [DEV_W:0] LIMIT = (DEV_W+1)'(IDSEL_N);

  generate
    for (genvar i = 0; i < IDSEL_N; i++) begin : g_sel
      assign idsel[i] = (dev == DEV_W'(i));
    end
  endgenerate

  assign in_range = ({1'b0, dev} < LIMIT);
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
  import cfg_router_pkg::*;
#(
  parameter int LOCAL_DEVS = 3
) (
  input  logic [31:0]      addr_q,
  input  logic [BUS_W-1:0] sec_bus,
  input  logic [BUS_W-1:0] sub_bus,
  output route_t           route,
  output logic             abort,
  output logic [31:0]      cyc_addr
);
  localparam logic [DEV_W-1:0] LOC_LIM = DEV_W'(LOCAL_DEVS);

  logic [BUS_W-1:0] bus;
  logic [DEV_W-1:0] dev;
  logic [FN_W-1:0]  fn;
  logic [REG_W-1:0] rg;
  logic [15:0]      idsel;
  logic             dev_ok;
  logic [31:0]      fwd;

  assign bus = addr_q[23:16];
  assign dev = addr_q[15:11];
  assign fn  = addr_q[10:8];
  assign rg  = addr_q[7:2];
  assign fwd = {8'h00, addr_q[23:2], 2'b00};

  cfg_idsel_gen #(.DEV_W(DEV_W), .IDSEL_N(16)) idsel_i (
    .dev      (dev),
    .idsel    (idsel),
    .in_range (dev_ok)
  );

  always_comb begin
    route    = RT_HUB;
    abort    = 1'b0;
    cyc_addr = fwd;
    if (bus == '0) begin
      if (dev < LOC_LIM) begin
        route = RT_LOCAL;
        abort = (fn != '0);
      end
    end else if (bus == sec_bus) begin
      route    = RT_TYPE0;
      abort    = !dev_ok;
      cyc_addr = {idsel, 5'b00000, fn, rg, 2'b00};
    end else if ((bus > sec_bus) && (bus <= sub_bus)) begin
      route    = RT_TYPE1;
      cyc_addr = fwd | 32'h1;
    end
  end
endmodule

// File: rtl/cfg_router.sv
module cfg_router
  import cfg_router_pkg::*;
#(
  parameter logic [15:0] ADDR_PORT  = 16'h0CF8,
  parameter logic [15:0] DATA_PORT  = 16'h0CFC,
  parameter int          LOCAL_DEVS = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        io_valid,
  input  logic        io_write,
  input  logic [15:0] io_addr,
  input  logic [31:0] io_wdata,
  input  logic [7:0]  sec_bus,
  input  logic [7:0]  sub_bus,
  input  logic [31:0] tgt_rdata,
  output logic        io_rvalid,
  output logic [31:0] io_rdata,
  output logic        cyc_valid,
  output logic        cyc_write,
  output logic [1:0]  cyc_route,
  output logic [31:0] cyc_addr,
  output logic [31:0] cyc_wdata,
  output logic        cyc_abort
);
  logic [31:0] addr_q;
  logic [31:0] data_q;
  logic        rd_pend;
  logic        rd_tgt;
  logic [31:0] rd_imm;

  route_t      dec_route;
  logic        dec_abort;
  logic [31:0] dec_addr;
  logic        hit_a;
  logic        hit_d;

  assign hit_a = io_valid && (io_addr == ADDR_PORT);
  assign hit_d = io_valid && (io_addr == DATA_PORT);

  cfg_decode #(.LOCAL_DEVS(LOCAL_DEVS)) dec_i (
    .addr_q   (addr_q),
    .sec_bus  (sec_bus),
    .sub_bus  (sub_bus),
    .route    (dec_route),
    .abort    (dec_abort),
    .cyc_addr (dec_addr)
  );

  // stage 1: register access, decode, issue
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      data_q    <= '0;
      rd_pend   <= 1'b0;
      rd_tgt    <= 1'b0;
      rd_imm    <= '0;
      cyc_valid <= 1'b0;
      cyc_write <= 1'b0;
      cyc_route <= '0;
      cyc_addr  <= '0;
      cyc_wdata <= '0;
      cyc_abort <= 1'b0;
    end else begin
      cyc_valid <= 1'b0;
      cyc_abort <= 1'b0;
      rd_pend   <= 1'b0;
      if (hit_a) begin
        if (io_write) begin
          addr_q <= {io_wdata[31:2], 2'b00};
        end else begin
          rd_pend <= 1'b1;
          rd_tgt  <= 1'b0;
          rd_imm  <= addr_q;
        end
      end
      if (hit_d) begin
        if (!addr_q[31]) begin
          if (io_write) begin
            data_q <= io_wdata;
          end else begin
            rd_pend <= 1'b1;
            rd_tgt  <= 1'b0;
            rd_imm  <= data_q;
          end
        end else begin
          cyc_route <= dec_route;
          cyc_addr  <= dec_addr;
          cyc_write <= io_write;
          cyc_wdata <= io_wdata;
          if (dec_abort) begin
            cyc_abort <= 1'b1;
            if (!io_write) begin
              rd_pend <= 1'b1;
              rd_tgt  <= 1'b0;
              rd_imm  <= '1;
            end
          end else begin
            cyc_valid <= 1'b1;
            if (io_write) begin
              data_q <= io_wdata;
            end else begin
              rd_pend <= 1'b1;
              rd_tgt  <= 1'b1;
            end
          end
        end
      end
    end
  end

  // stage 2: read return
  always_ff @(posedge clk) begin
    if (rst) begin
      io_rvalid <= 1'b0;
      io_rdata  <= '0;
    end else begin
      io_rvalid <= rd_pend;
      if (rd_pend) begin
        io_rdata <= rd_tgt ? tgt_rdata : rd_imm;
      end
    end
  end
endmodule

// File: rtl/cfg_router_chk.sv
module cfg_router_chk #(
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
  input logic        clk,
  input logic        rst,
  input logic        io_valid,
  input logic        io_write,
  input logic [15:0] io_addr,
  input logic        io_rvalid,
  input logic [31:0] io_rdata,
  input logic        cyc_valid,
  input logic        cyc_write,
  input logic [1:0]  cyc_route,
  input logic [31:0] cyc_addr,
  input logic        cyc_abort
);
  AST_TYPE0_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && cyc_route == 2'd1) |-> ($countones(cyc_addr[31:16]) == 1 && cyc_addr[15:11] == 5'd0 && cyc_addr[1:0] == 2'b00)); // R5

  AST_TYPE1_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && cyc_route == 2'd2) |-> cyc_addr[1:0] == 2'b01); // R7

  AST_LOCAL_FN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && cyc_route == 2'd0) |-> cyc_addr[10:8] == 3'd0); // R4

  AST_ABORT_NO_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cyc_abort |-> !cyc_valid); // R4

  AST_ABORT_READ_ONES: assert property (@(posedge clk) disable iff (rst)
    (io_rvalid && $past(cyc_abort) && !$past(cyc_write)) |-> io_rdata == 32'hFFFF_FFFF); // R9

  AST_CYCLE_FROM_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid || cyc_abort) |-> $past(io_valid && io_addr == DATA_PORT)); // R10

  AST_RVALID_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    io_rvalid |-> $past(io_valid && !io_write && (io_addr == ADDR_PORT || io_addr == DATA_PORT), 2)); // R11
endmodule

bind cfg_router cfg_router_chk #(.ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .io_valid  (io_valid),
  .io_write  (io_write),
  .io_addr   (io_addr),
  .io_rvalid (io_rvalid),
  .io_rdata  (io_rdata),
  .cyc_valid (cyc_valid),
  .cyc_write (cyc_write),
  .cyc_route (cyc_route),
  .cyc_addr  (cyc_addr),
  .cyc_abort (cyc_abort)
);

// File: tb/cfg_router_tb_top.sv
module cfg_router_tb_top;
  localparam logic [15:0] PA = 16'h0CF8;
  localparam logic [15:0] PD = 16'h0CFC;
  localparam logic [31:0] K  = 32'h5A5A_0F0F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_valid = 1'b0;
  logic        io_write = 1'b0;
  logic [15:0] io_addr = '0;
  logic [31:0] io_wdata = '0;
  logic [7:0]  sec_bus = 8'd5;
  logic [7:0]  sub_bus = 8'd9;
  logic [31:0] tgt_rdata;
  logic        io_rvalid;
  logic [31:0] io_rdata;
  logic        cyc_valid, cyc_write, cyc_abort;
  logic [1:0]  cyc_route;
  logic [31:0] cyc_addr, cyc_wdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic        s_cv, s_cw, s_ab, s_rv;
  logic [1:0]  s_rt;
  logic [31:0] s_ca, s_wd, s_rd;

  always #10 clk = ~clk;

  assign tgt_rdata = ~cyc_addr ^ K;

  cfg_router dut_i (
    .clk(clk), .rst(rst), .io_valid(io_valid), .io_write(io_write),
    .io_addr(io_addr), .io_wdata(io_wdata), .sec_bus(sec_bus), .sub_bus(sub_bus),
    .tgt_rdata(tgt_rdata), .io_rvalid(io_rvalid), .io_rdata(io_rdata),
    .cyc_valid(cyc_valid), .cyc_write(cyc_write), .cyc_route(cyc_route),
    .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata), .cyc_abort(cyc_abort)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    io_valid = 1'b1; io_write = wr; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_valid = 1'b0;
    s_cv = cyc_valid; s_cw = cyc_write; s_rt = cyc_route;
    s_ca = cyc_addr;  s_wd = cyc_wdata; s_ab = cyc_abort;
    @(negedge clk);
    s_rv = io_rvalid; s_rd = io_rdata;
  endtask

  function automatic void model(input logic [31:0] a, output logic [1:0] rt,
                                output logic ab, output logic [31:0] ca);
    int bus, dev, fn, rg;
    bus = int'(a[23:16]); dev = int'(a[15:11]); fn = int'(a[10:8]); rg = int'(a[7:2]);
    ab = 1'b0;
    ca = 32'(bus * 65536 + dev * 2048 + fn * 256 + rg * 4);
    if (bus == 0) begin
      rt = (dev < 3) ? 2'd0 : 2'd3;
      ab = (dev < 3) && (fn != 0);
    end else if (bus == int'(sec_bus)) begin
      rt = 2'd1;
      ab = (dev > 15);
      ca = 32'(fn * 256 + rg * 4);
      if (dev <= 15) ca = ca | (32'h1 << (16 + dev));
    end else if (bus > int'(sec_bus) && bus <= int'(sub_bus)) begin
      rt = 2'd2;
      ca = ca + 32'd1;
    end else begin
      rt = 2'd3;
    end
  endfunction

  function automatic string tag_of(input logic [1:0] rt, input logic ab);
    case (rt)
      2'd0: return ab ? "R4" : "R3";
      2'd1: return ab ? "R6" : "R5";
      2'd2: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int buses[8] = '{0, 1, 4, 5, 6, 9, 10, 255};
    logic [1:0]  e_rt;
    logic        e_ab;
    logic [31:0] e_ca, e_ca2;
    string       tg;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset rvalid", 32'(io_rvalid), 0);
    chk("R1 reset cyc_valid", 32'(cyc_valid), 0);

    // reset values
    acc(1'b0, PA, 0);
    chk("R1 reset addr", s_rd, 32'h0);
    chk("R1 rvalid", 32'(s_rv), 1);
    acc(1'b0, PD, 0);
    chk("R2 reset data", s_rd, 32'h0);

    // address register low bits
    acc(1'b1, PA, 32'h7ABC_DEF3);
    acc(1'b0, PA, 0);
    chk("R1 low bits zero", s_rd, 32'h7ABC_DEF0);

    // plain window while disabled
    acc(1'b1, PD, 32'hCAFE_F00D);
    chk("R2 no cycle on write", {30'd0, s_cv, s_ab}, 0);
    acc(1'b0, PD, 0);
    chk("R2 no cycle on read", {30'd0, s_cv, s_ab}, 0);
    chk("R2 window data", s_rd, 32'hCAFE_F00D);

    // decode sweep
    for (int bi = 0; bi < 8; bi++) begin
      for (int dev = 0; dev < 32; dev++) begin
        for (int fk = 0; fk < 2; fk++) begin
          logic [31:0] a;
          int fn, rg;
          fn = fk * 5;
          rg = (dev * 3 + buses[bi]) % 64;
          a = 32'h8000_0000 | 32'(buses[bi] * 65536 + dev * 2048 + fn * 256 + rg * 4);
          model(a, e_rt, e_ab, e_ca);
          tg = tag_of(e_rt, e_ab);
          acc(1'b1, PA, a);
          acc(1'b0, PD, 0);
          chk({tg, " cyc_valid"}, 32'(s_cv), 32'(!e_ab));
          chk({tg, " abort"}, 32'(s_ab), 32'(e_ab));
          chk({tg, " route"}, 32'(s_rt), 32'(e_rt));
          if (!e_ab) chk({tg, " addr"}, s_ca, e_ca);
          chk({tg, " R10 rvalid"}, 32'(s_rv), 1);
          chk({tg, " R9 rdata"}, s_rd, e_ab ? 32'hFFFF_FFFF : (~e_ca ^ K));
        end
      end
    end

    // routed write then aborted write
    acc(1'b1, PA, 32'h8000_0000 | 32'(0 * 65536 + 1 * 2048 + 0 * 256 + 7 * 4));
    acc(1'b1, PD, 32'h2222_2222);
    chk("R9 routed write valid", {30'd0, s_cv, s_cw}, 32'd3);
    chk("R9 routed wdata", s_wd, 32'h2222_2222);
    chk("R3 write addr", s_ca, 32'(1 * 2048 + 7 * 4));
    acc(1'b1, PA, 32'h8000_0000 | 32'(1 * 2048 + 2 * 256));
    acc(1'b1, PD, 32'h1111_1111);
    chk("R9 aborted write no cycle", {30'd0, s_cv, s_ab}, 32'd1);
    acc(1'b1, PA, 32'h0);
    acc(1'b0, PD, 0);
    chk("R9 window kept", s_rd, 32'h2222_2222);

    // ignored addresses
    acc(1'b1, PA, 32'h0012_3400);
    acc(1'b1, 16'h0CF9, 32'hFFFF_FFFF);
    chk("R11 write ignored no cycle", {30'd0, s_cv, s_ab}, 0);
    acc(1'b1, 16'h0CFD, 32'h8765_4321);
    acc(1'b0, 16'h0CF4, 0);
    chk("R11 read no response", {30'd0, s_rv, s_cv}, 0);
    acc(1'b0, PA, 0);
    chk("R11 addr unchanged", s_rd, 32'h0012_3400);
    acc(1'b0, PD, 0);
    chk("R11 window unchanged", s_rd, 32'h2222_2222);

    // back-to-back: addr write, window read, addr write, window read
    model(32'h8005_1A10, e_rt, e_ab, e_ca);
    model(32'h8007_2B24, e_rt, e_ab, e_ca2);
    @(negedge clk);
    io_valid = 1'b1; io_write = 1'b1; io_addr = PA; io_wdata = 32'h8005_1A10;
    @(negedge clk);
    io_write = 1'b0; io_addr = PD;
    @(negedge clk);
    chk("R10 b2b first decode", {29'd0, cyc_valid, cyc_route}, 32'h5);
    chk("R10 b2b first addr", cyc_addr, e_ca);
    io_write = 1'b1; io_addr = PA; io_wdata = 32'h8007_2B24;
    @(negedge clk);
    chk("R10 b2b first rdata", io_rdata, ~e_ca ^ K);
    chk("R10 b2b first rvalid, no cycle", {30'd0, io_rvalid, cyc_valid}, 32'd2);
    io_write = 1'b0; io_addr = PD;
    @(negedge clk);
    io_valid = 1'b0;
    chk("R10 b2b second decode", {29'd0, cyc_valid, cyc_route}, 32'h6);
    chk("R10 b2b second addr", cyc_addr, e_ca2);
    @(negedge clk);
    chk("R10 b2b second rdata", io_rdata, ~e_ca2 ^ K);
    chk("R10 b2b single pulse", 32'(cyc_valid), 0);
    @(negedge clk);
    chk("R10 rvalid single pulse", 32'(io_rvalid), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule